// File: doc/BRIEF.md
# Card Supply Class Sequencer

This block sits on the reader side of a contact card interface and settles which supply voltage an inserted card is run at. When a card is detected it powers the card at the lowest voltage class the reader is configured to offer, holds the card's reset low for a fixed ramp period and then releases it. It then waits for the receive path to report the start of the card's answer-to-reset.

If no answer arrives within a programmable number of card-clock ticks, the sequencer removes power. It waits for a programmable off-time and then tries the next higher supported class. When an answer arrives, the current class is locked in and reported. When no higher class remains, the sequencer reports failure with power off. Pulling the card out at any moment returns it to idle with power removed.

There are three classes: low (1.8 V), mid (3 V) and high (5 V). The supported-class mask selects among them. With only the high class enabled, a reader applies 5 V straight away.

Top module: `sup_class_seq`

## Requirements
- R1: After reset, `pwr_en_o`, `card_rst_n_o`, `locked_o` and `fail_o` are 0, and `vsel_o` and `active_cls_o` are 0.
- R2: With the idle sequencer and `card_present` high at a clock edge, power is on from that edge. `vsel_o` then carries the lowest supported class. Class codes are 1 for low, 2 for mid and 3 for high. Mask bit 0 enables low, bit 1 enables mid and bit 2 enables high.
- R3: With a mask of 3'b100, the first attempt is made at code 3 with no lower attempt.
- R4: `card_rst_n_o` rises exactly RAMP_CYC clock cycles after power is applied. It is low whenever power is off.
- R5: Once the card reset is released, only clock edges with `clk_tick` high count toward the timeout. Power drops on the edge of the `cfg_atr_timeout`-th such tick if `atr_seen` has not been high. A value of 0 behaves as 1.
- R6: Between attempts, power stays off with `vsel_o` = 0 for `cfg_off_time` cycles, where 0 behaves as 1. Power then returns at the next class.
- R7: Escalation goes strictly upward through the classes and skips classes not enabled in the mask. An example is low then high for mask 3'b101.
- R8: If `atr_seen` is high while the sequencer waits for an answer, `locked_o` rises on the next edge. `active_cls_o` then shows the current class, and power and the class stay unchanged while the card remains.
- R9: A timeout at the highest supported class sets `fail_o` and turns power off. This state holds until the card is removed.
- R10: When `card_present` is low at an edge, all outputs return to their reset values on that edge.
- R11: An inserted card with an all-zero mask raises `fail_o` on the first edge and never applies power.
- R12: `atr_seen` is ignored while the card reset is still held during the power ramp. In that case no lock occurs and the later timeout still escalates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_present | input | 1 | Card detected in the slot |
| class_mask | input | 3 | Supported classes: bit0 low, bit1 mid, bit2 high |
| clk_tick | input | 1 | One pulse per card-clock cycle |
| atr_seen | input | 1 | Receive path saw the start of the answer-to-reset |
| cfg_atr_timeout | input | TMO_W | Answer timeout in card-clock ticks |
| cfg_off_time | input | OFF_W | Power-off gap in clock cycles |
| pwr_en_o | output | 1 | Card supply enable |
| vsel_o | output | 2 | Voltage class code applied (0 when off) |
| card_rst_n_o | output | 1 | Card reset, low = held in reset |
| active_cls_o | output | 2 | Class code locked after a successful answer |
| locked_o | output | 1 | Card answered; class settled |
| fail_o | output | 1 | No supported class produced an answer |

## Verification
Every output is a register, so each result is due a fixed number of edges after its cause. Power and class follow insertion on the same edge. Card reset follows power after RAMP_CYC edges. The power drop follows reset release after the timeout count of ticks. Power returns the off-time count of edges after the drop. Lock and removal take effect one edge after the input. The bench drives inputs and samples outputs on the falling edge. It measures each interval by counting falling edges until the awaited output change and compares the count with these figures, using a bounded range only where the tick divider makes the phase uncertain.

// File: rtl/sup_class_pkg.sv
package sup_class_pkg;

    localparam int NUM_CLS = 3;
    localparam int CLS_W   = $clog2(NUM_CLS + 1);

    localparam logic [CLS_W-1:0] CLS_NONE = 2'd0;
    localparam logic [CLS_W-1:0] CLS_LOW  = 2'd1;
    localparam logic [CLS_W-1:0] CLS_MID  = 2'd2;
    localparam logic [CLS_W-1:0] CLS_HIGH = 2'd3;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_RAMP   = 3'd1,
        SQ_WAIT   = 3'd2,
        SQ_GAP    = 3'd3,
        SQ_LOCKED = 3'd4,
        SQ_FAILED = 3'd5
    } seq_state_e;

endpackage

// File: rtl/sup_class_pick.sv
module sup_class_pick
    import sup_class_pkg::*;
(
    input  logic [NUM_CLS-1:0] mask,
    input  logic [CLS_W-1:0]   floor_cls,
    output logic               found,
    output logic [CLS_W-1:0]   pick
);
    logic [NUM_CLS-1:0] cand;

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cand
        assign cand[g] = mask[g] && ((g + 1) > int'(floor_cls));
    end

    always_comb begin
        found = 1'b0;
        pick  = CLS_NONE;
        for (int i = NUM_CLS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                pick  = CLS_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/sup_expire.sv
module sup_expire #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W:0] cnt_p1;
    logic [W:0] lim_eff;

    always_comb begin
        cnt_p1  = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
        lim_eff = (limit == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, limit};
        done    = (cnt_p1 >= lim_eff);
    end
endmodule

// File: rtl/sup_class_seq.sv
module sup_class_seq
    import sup_class_pkg::*;
#(
    parameter int RAMP_CYC = 8,
    parameter int TMO_W    = 16,
    parameter int OFF_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               card_present,
    input  logic [2:0]         class_mask,
    input  logic               clk_tick,
    input  logic               atr_seen,
    input  logic [TMO_W-1:0]   cfg_atr_timeout,
    input  logic [OFF_W-1:0]   cfg_off_time,
    output logic               pwr_en_o,
    output logic [1:0]         vsel_o,
    output logic               card_rst_n_o,
    output logic [1:0]         active_cls_o,
    output logic               locked_o,
    output logic               fail_o
);
    localparam int RMP_W = $clog2(RAMP_CYC + 1);
    localparam int CW0   = (TMO_W > OFF_W) ? TMO_W : OFF_W;
    localparam int CNT_W = (CW0 > RMP_W) ? CW0 : RMP_W;

    typedef struct packed {
        seq_state_e       st;
        logic [CLS_W-1:0] cls;
        logic [CLS_W-1:0] vsel;
        logic [CLS_W-1:0] act;
        logic [CNT_W-1:0] cnt;
        logic             pwr;
        logic             crst_n;
        logic             locked;
        logic             fail;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        st: SQ_IDLE, cls: CLS_NONE, vsel: CLS_NONE, act: CLS_NONE,
        cnt: '0, pwr: 1'b0, crst_n: 1'b0, locked: 1'b0, fail: 1'b0
    };

    seq_regs_t r_q, r_d;

    logic             first_ok, next_ok;
    logic [CLS_W-1:0] first_cls, next_cls;
    logic             ramp_done, tmo_done, gap_done;

    sup_class_pick u_pick_first (
        .mask      (class_mask),
        .floor_cls (CLS_NONE),
        .found     (first_ok),
        .pick      (first_cls)
    );

    sup_class_pick u_pick_next (
        .mask      (class_mask),
        .floor_cls (r_q.cls),
        .found     (next_ok),
        .pick      (next_cls)
    );

    sup_expire #(.W(CNT_W)) u_exp_ramp (
        .cnt   (r_q.cnt),
        .limit (CNT_W'(RAMP_CYC)),
        .done  (ramp_done)
    );

    sup_expire #(.W(CNT_W)) u_exp_tmo (
        .cnt   (r_q.cnt),
        .limit (CNT_W'(cfg_atr_timeout)),
        .done  (tmo_done)
    );

    sup_expire #(.W(CNT_W)) u_exp_gap (
        .cnt   (r_q.cnt),
        .limit (CNT_W'(cfg_off_time)),
        .done  (gap_done)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SQ_IDLE: begin
                if (card_present) begin
                    if (first_ok) begin
                        r_d.st   = SQ_RAMP;
                        r_d.cls  = first_cls;
                        r_d.vsel = first_cls;
                        r_d.pwr  = 1'b1;
                        r_d.cnt  = '0;
                    end else begin
                        r_d.st   = SQ_FAILED;
                        r_d.fail = 1'b1;
                    end
                end
            end
            SQ_RAMP: begin
                if (ramp_done) begin
                    r_d.st     = SQ_WAIT;
                    r_d.crst_n = 1'b1;
                    r_d.cnt    = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            SQ_WAIT: begin
                if (atr_seen) begin
                    r_d.st     = SQ_LOCKED;
                    r_d.locked = 1'b1;
                    r_d.act    = r_q.cls;
                end else if (clk_tick) begin
                    if (tmo_done) begin
                        r_d.pwr    = 1'b0;
                        r_d.crst_n = 1'b0;
                        r_d.vsel   = CLS_NONE;
                        r_d.cnt    = '0;
                        if (next_ok) begin
                            r_d.st  = SQ_GAP;
                            r_d.cls = next_cls;
                        end else begin
                            r_d.st   = SQ_FAILED;
                            r_d.fail = 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            SQ_GAP: begin
                if (gap_done) begin
                    r_d.st   = SQ_RAMP;
                    r_d.pwr  = 1'b1;
                    r_d.vsel = r_q.cls;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            SQ_LOCKED, SQ_FAILED: begin
                r_d = r_q;
            end
            default: r_d = REGS_RST;
        endcase

        if (!card_present) begin
            r_d = REGS_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign pwr_en_o     = r_q.pwr;
    assign vsel_o       = r_q.vsel;
    assign card_rst_n_o = r_q.crst_n;
    assign active_cls_o = r_q.act;
    assign locked_o     = r_q.locked;
    assign fail_o       = r_q.fail;

endmodule

// File: rtl/sup_class_seq_chk.sv
module sup_class_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       card_present,
    input logic       pwr_en_o,
    input logic [1:0] vsel_o,
    input logic       card_rst_n_o,
    input logic [1:0] active_cls_o,
    input logic       locked_o,
    input logic       fail_o
);
    a_r10_removal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !card_present |=> (!pwr_en_o && !locked_o && !fail_o && vsel_o == 2'd0));

    a_r6_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en_o |-> (vsel_o == 2'd0 && !card_rst_n_o));

    a_r4_reset_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_n_o |-> pwr_en_o);

    a_r9_fail_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (!pwr_en_o && !locked_o));

    a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && card_present) |=> (locked_o && $stable(active_cls_o) && pwr_en_o));

    a_r7_class_steady_while_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en_o && $past(pwr_en_o)) |-> $stable(vsel_o));
endmodule

bind sup_class_seq sup_class_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .card_present (card_present),
    .pwr_en_o     (pwr_en_o),
    .vsel_o       (vsel_o),
    .card_rst_n_o (card_rst_n_o),
    .active_cls_o (active_cls_o),
    .locked_o     (locked_o),
    .fail_o       (fail_o)
);

// File: tb/sup_class_seq_test.sv
`timescale 1ns/1ps
module sup_class_seq_test;
    localparam int RAMP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_present = 1'b0;
    logic [2:0]  class_mask = 3'b000;
    logic        clk_tick = 1'b1;
    logic        atr_seen = 1'b0;
    logic [15:0] cfg_atr_timeout = 16'd5;
    logic [11:0] cfg_off_time = 12'd3;
    logic        pwr_en_o, card_rst_n_o, locked_o, fail_o;
    logic [1:0]  vsel_o, active_cls_o;

    int tick_every = 1;
    int tdiv = 0;
    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sup_class_seq #(.RAMP_CYC(RAMP), .TMO_W(16), .OFF_W(12)) uut (
        .clk, .rst_n, .card_present, .class_mask, .clk_tick, .atr_seen,
        .cfg_atr_timeout, .cfg_off_time, .pwr_en_o, .vsel_o, .card_rst_n_o,
        .active_cls_o, .locked_o, .fail_o
    );

    always @(negedge clk) begin
        if (tick_every <= 1) begin
            clk_tick <= 1'b1;
        end else begin
            tdiv     <= (tdiv + 1) % tick_every;
            clk_tick <= (tdiv == 0);
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count falling edges until pwr_en_o equals lvl
    task automatic wait_pwr(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pwr_en_o !== lvl && n < 2000);
    endtask

    task automatic wait_rst(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (card_rst_n_o !== 1'b1 && n < 2000);
    endtask

    task automatic remove_card();
        card_present = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic insert(input logic [2:0] m);
        class_mask   = m;
        card_present = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pwr_en_o == 0 && card_rst_n_o == 0, "R1 power/reset", pwr_en_o, 0);
        check(vsel_o == 0 && active_cls_o == 0, "R1 class outputs", vsel_o, 0);
        check(locked_o == 0 && fail_o == 0, "R1 status", fail_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Full escalation low -> mid -> high -> fail
    task automatic t_full_escalation();
        int n;
        cfg_atr_timeout = 5; cfg_off_time = 3;
        insert(3'b111);
        check(pwr_en_o == 1 && vsel_o == 1, "R2 first class low", vsel_o, 1);
        wait_rst(n);
        check(n == RAMP, "R4 ramp length", n, RAMP);
        wait_pwr(1'b0, n);
        check(n == 5, "R5 timeout ticks", n, 5);
        check(vsel_o == 0 && card_rst_n_o == 0, "R6 quiet gap", vsel_o, 0);
        wait_pwr(1'b1, n);
        check(n == 3, "R6 gap length", n, 3);
        check(vsel_o == 2, "R7 second class mid", vsel_o, 2);
        wait_rst(n);
        wait_pwr(1'b0, n);
        wait_pwr(1'b1, n);
        check(vsel_o == 3, "R7 third class high", vsel_o, 3);
        wait_rst(n);
        wait_pwr(1'b0, n);
        check(n == 5 && fail_o == 1, "R9 fail at last class", fail_o, 1);
        repeat (10) @(negedge clk);
        check(fail_o == 1 && pwr_en_o == 0, "R9 fail holds unpowered", pwr_en_o, 0);
        remove_card();
        check(fail_o == 0 && pwr_en_o == 0, "R10 removal clears fail", fail_o, 0);
    endtask

    task automatic t_high_only();
        int n;
        insert(3'b100);
        check(pwr_en_o == 1 && vsel_o == 3, "R3 high applied directly", vsel_o, 3);
        wait_rst(n);
        atr_seen = 1'b1;
        @(negedge clk);
        atr_seen = 1'b0;
        check(locked_o == 1 && active_cls_o == 3, "R8 lock at high", active_cls_o, 3);
        repeat (20) @(negedge clk);
        check(locked_o == 1 && pwr_en_o == 1 && vsel_o == 3, "R8 lock holds", vsel_o, 3);
        remove_card();
    endtask

    task automatic t_skip_mid();
        int n;
        cfg_atr_timeout = 4; cfg_off_time = 2;
        insert(3'b101);
        check(vsel_o == 1, "R2 lowest of 101", vsel_o, 1);
        wait_rst(n);
        wait_pwr(1'b0, n);
        wait_pwr(1'b1, n);
        check(vsel_o == 3, "R7 skip mid", vsel_o, 3);
        wait_rst(n);
        atr_seen = 1'b1;
        @(negedge clk);
        atr_seen = 1'b0;
        check(locked_o == 1 && active_cls_o == 3, "R8 lock after skip", active_cls_o, 3);
        remove_card();
    endtask

    task automatic t_empty_mask();
        insert(3'b000);
        check(fail_o == 1, "R11 empty mask fails", fail_o, 1);
        repeat (5) @(negedge clk);
        check(pwr_en_o == 0 && vsel_o == 0, "R11 never powered", pwr_en_o, 0);
        remove_card();
    endtask

    task automatic t_atr_in_ramp();
        int n;
        cfg_atr_timeout = 5; cfg_off_time = 3;
        insert(3'b011);
        atr_seen = 1'b1;
        @(negedge clk);
        atr_seen = 1'b0;
        wait_rst(n);
        check(locked_o == 0, "R12 answer during ramp ignored", locked_o, 0);
        wait_pwr(1'b0, n);
        wait_pwr(1'b1, n);
        check(vsel_o == 2 && locked_o == 0, "R12 escalation proceeds", vsel_o, 2);
        remove_card();
    endtask

    task automatic t_remove_in_wait();
        int n;
        cfg_atr_timeout = 200;
        insert(3'b010);
        wait_rst(n);
        repeat (3) @(negedge clk);
        card_present = 1'b0;
        @(negedge clk);
        check(pwr_en_o == 0 && card_rst_n_o == 0 && vsel_o == 0, "R10 removal mid-wait", pwr_en_o, 0);
        @(negedge clk);
    endtask

    task automatic t_tick_divider();
        int n;
        cfg_atr_timeout = 6;
        tick_every = 4;
        insert(3'b011);
        wait_rst(n);
        wait_pwr(1'b0, n);
        check(n >= 4 * 5 + 1 && n <= 4 * 6 + 1, "R5 ticks gated", n, 24);
        tick_every = 1;
        remove_card();
    endtask

    task automatic t_zero_settings();
        int n;
        cfg_atr_timeout = 0; cfg_off_time = 0;
        insert(3'b011);
        wait_rst(n);
        wait_pwr(1'b0, n);
        check(n == 1, "R5 zero timeout as one", n, 1);
        wait_pwr(1'b1, n);
        check(n == 1 && vsel_o == 2, "R6 zero gap as one", n, 1);
        remove_card();
    endtask

    initial begin
        t_reset();
        t_full_escalation();
        t_high_only();
        t_skip_mid();
        t_empty_mask();
        t_atr_in_ramp();
        t_remove_in_wait();
        t_tick_divider();
        t_zero_settings();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule